// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a binary counter, `WIDTH` bits wide (8 by default). Every change to its register happens on the rising clock edge. On each edge it does one of four things: it loads a parallel word, holds its value, steps up by one, or steps down by one. The choice depends on an active-low load strobe, two active-low count enables and a direction select. The count wraps modulo 2^WIDTH in both directions.

An active-low terminal flag marks the last value before a wrap in the current direction. That value is all ones when counting up and all zeros when counting down. The flag is gated only by the trickle enable, and it follows the direction and trickle inputs without waiting for a clock. Wider counters are built by feeding one stage's terminal flag into the next stage's trickle enable. The parallel enable is shared by all stages and serves as the local run/stop control.

A synchronous clear is provided for initialisation. The register is driven by a small operating mode, recomputed every cycle. Its modes are:

- CLEAR, entered when `sync_clear` is high.
- LOAD, entered when `ld_n` is low.
- HOLD, entered when either enable is high.
- INC, entered when both enables are low and `dir_up` is 1.
- DEC, entered when both enables are low and `dir_up` is 0.

Any mode can move to any other on the next edge. The selection priority is CLEAR, then LOAD, then HOLD, then INC or DEC.

Top module: `updown_counter`

## Requirements
- R1: With `sync_clear` high at a rising edge, `count` becomes 0 after that edge, whatever the other inputs are.
- R2: With `sync_clear` low and `ld_n` low at an edge, `count` takes the value of `din`, whatever the enables and `dir_up` are.
- R3: With `sync_clear` and `ld_n` high and `en_par_n` high, `count` keeps its value across the edge.
- R4: With `sync_clear` and `ld_n` high and `en_trk_n` high, `count` keeps its value and `term_n` is 1.
- R5: With `sync_clear` and `ld_n` high, both enables low and `dir_up` = 1, `count` increments by one; all ones wraps to 0.
- R6: With `sync_clear` and `ld_n` high, both enables low and `dir_up` = 0, `count` decrements by one; 0 wraps to all ones.
- R7: `term_n` is 0 exactly when `en_trk_n` is 0 and either `dir_up` = 1 with `count` all ones, or `dir_up` = 0 with `count` zero. It responds within the same cycle to `dir_up` and `en_trk_n`.
- R8: `term_n` does not depend on `en_par_n` or `ld_n`.
- R9: Two stages form a 2×WIDTH-bit up/down counter when they share `ld_n`, `dir_up` and `en_par_n`, and the low stage's `term_n` drives the high stage's `en_trk_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| sync_clear | input | 1 | Synchronous clear to zero, highest priority |
| ld_n | input | 1 | Active-low parallel load |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| en_par_n | input | 1 | Active-low local count enable |
| en_trk_n | input | 1 | Active-low cascade count enable, also gates `term_n` |
| din | input | WIDTH | Parallel load word |
| count | output | WIDTH | Counter value |
| term_n | output | 1 | Active-low terminal flag |

## Verification
The bench drives the wrap points directly in both directions. A counter with a bad carry or borrow would show up there: one that stuck at all ones or 0, or that wrapped to the wrong end, would leave `count` diverging from the reference model. It samples `term_n` right after changing only `dir_up` or `en_trk_n`. A registered flag, or one that looked at the wrong extreme for the direction, would lag or sit at the opposite end. It also toggles `en_par_n` and `ld_n` while the flag is active, so a flag wrongly gated by those inputs would drop. A two-stage chain is compared against a double-width model across wraps in both directions, which exposes any stage that steps the high byte without the low stage's carry.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    typedef enum logic [2:0] {
        OP_CLEAR = 3'd0,
        OP_LOAD  = 3'd1,
        OP_HOLD  = 3'd2,
        OP_INC   = 3'd3,
        OP_DEC   = 3'd4
    } ctr_op_e;
endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
    import ctr_pkg::*;
(
    input  logic    sync_clear,
    input  logic    ld_n,
    input  logic    dir_up,
    input  logic    en_par_n,
    input  logic    en_trk_n,
    output ctr_op_e op
);
    // Priority: clear, then load, then hold, then a step in the selected direction.
    always_comb begin
        if (sync_clear)
            op = OP_CLEAR;
        else if (!ld_n)
            op = OP_LOAD;
        else if (en_par_n || en_trk_n)
            op = OP_HOLD;
        else if (dir_up)
            op = OP_INC;
        else
            op = OP_DEC;
    end
endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg
    import ctr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  ctr_op_e          op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    // Next-value selection for each operating mode.
    always_comb begin
        unique case (op)
            OP_CLEAR: cnt_d = '0;
            OP_LOAD:  cnt_d = din;
            OP_INC:   cnt_d = cnt_q + ONE;
            OP_DEC:   cnt_d = cnt_q - ONE;
            default:  cnt_d = cnt_q;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/ctr_term_detect.sv
module ctr_term_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] count,
    input  logic             dir_up,
    input  logic             en_trk_n,
    output logic             term_n
);
    logic at_top;
    logic at_bottom;
    logic at_edge;

    assign at_top    = &count;
    assign at_bottom = ~|count;

    // Combinational path from direction and trickle enable to the flag.
    always_comb begin
        at_edge = dir_up ? at_top : at_bottom;
        term_n  = ~(at_edge & ~en_trk_n);
    end
endmodule

// File: rtl/updown_counter.sv
module updown_counter
    import ctr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             sync_clear,
    input  logic             ld_n,
    input  logic             dir_up,
    input  logic             en_par_n,
    input  logic             en_trk_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             term_n
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    ctr_op_e op;

    ctr_op_decode u_dec (
        .sync_clear (sync_clear),
        .ld_n       (ld_n),
        .dir_up     (dir_up),
        .en_par_n   (en_par_n),
        .en_trk_n   (en_trk_n),
        .op         (op)
    );

    ctr_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .op    (op),
        .din   (din),
        .count (count)
    );

    ctr_term_detect #(.WIDTH(WIDTH)) u_term (
        .count    (count),
        .dir_up   (dir_up),
        .en_trk_n (en_trk_n),
        .term_n   (term_n)
    );

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        sync_clear |=> count == '0); // R1
    AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (sync_clear)
        !ld_n |=> count == $past(din)); // R2
    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (sync_clear)
        (ld_n && en_par_n) |=> $stable(count)); // R3
    AST_TRK_HOLD: assert property (@(posedge clk) disable iff (sync_clear)
        (ld_n && en_trk_n) |=> $stable(count)); // R4
    AST_TRK_IDLE_FLAG: assert property (@(posedge clk) disable iff (sync_clear)
        en_trk_n |-> term_n); // R4
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (sync_clear)
        (ld_n && !en_par_n && !term_n && dir_up) |=> count == '0); // R5
    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (sync_clear)
        (ld_n && !en_par_n && !term_n && !dir_up) |=> count == ALL_ONES); // R6
    AST_FLAG_AT_EDGE: assert property (@(posedge clk) disable iff (sync_clear)
        !term_n |-> (dir_up ? (count == ALL_ONES) : (count == '0))); // R7
endmodule

// File: tb/tb_updown_counter.sv
module tb_updown_counter;
    localparam int W = 8;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         sync_clear, ld_n, dir_up, en_par_n, en_trk_n;
    logic [W-1:0] din;
    logic [W-1:0] count;
    logic         term_n;

    updown_counter #(.WIDTH(W)) dut (
        .clk(clk), .sync_clear(sync_clear), .ld_n(ld_n), .dir_up(dir_up),
        .en_par_n(en_par_n), .en_trk_n(en_trk_n), .din(din),
        .count(count), .term_n(term_n)
    );

    // Two-stage chain for R9.
    logic          c_clr, c_ld_n, c_up, c_par_n, c_trk_n;
    logic [2*W-1:0] c_din;
    logic [W-1:0]  lo_cnt, hi_cnt;
    logic          lo_term_n, hi_term_n;

    updown_counter #(.WIDTH(W)) stage_lo (
        .clk(clk), .sync_clear(c_clr), .ld_n(c_ld_n), .dir_up(c_up),
        .en_par_n(c_par_n), .en_trk_n(c_trk_n), .din(c_din[W-1:0]),
        .count(lo_cnt), .term_n(lo_term_n)
    );
    updown_counter #(.WIDTH(W)) stage_hi (
        .clk(clk), .sync_clear(c_clr), .ld_n(c_ld_n), .dir_up(c_up),
        .en_par_n(c_par_n), .en_trk_n(lo_term_n), .din(c_din[2*W-1:W]),
        .count(hi_cnt), .term_n(hi_term_n)
    );

    int checks = 0;
    int errors = 0;
    int model = 0;
    int model16 = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_term(input int v, input bit up, input bit trk_n, input int top);
        return (!trk_n && (up ? (v == top) : (v == 0))) ? 0 : 1;
    endfunction

    // One cycle on the main counter: drive at the falling edge, check the flag,
    // advance the model, then check the count at the next falling edge.
    task automatic step(input bit clr, input bit l_n, input bit up, input bit p_n,
                        input bit t_n, input int d);
        string tag;
        sync_clear = clr; ld_n = l_n; dir_up = up; en_par_n = p_n; en_trk_n = t_n;
        din = W'(d);
        #1;
        if (!clr)
            check(term_n == exp_term(model, up, t_n, MAXV)[0], "R7/R8 flag", term_n,
                  exp_term(model, up, t_n, MAXV));
        if (clr)            begin model = 0;                    tag = "R1 clear"; end
        else if (!l_n)      begin model = d & MAXV;             tag = "R2 load"; end
        else if (p_n)       tag = "R3 hold";
        else if (t_n)       tag = "R4 hold";
        else if (up)        begin model = (model + 1) & MAXV;   tag = "R5 up"; end
        else                begin model = (model - 1) & MAXV;   tag = "R6 down"; end
        @(negedge clk);
        check(int'(count) == model, tag, count, model);
    endtask

    task automatic cstep(input bit l_n, input bit up, input bit p_n, input bit t_n,
                         input int d);
        int top16;
        top16 = (1 << (2 * W)) - 1;
        c_clr = 1'b0; c_ld_n = l_n; c_up = up; c_par_n = p_n; c_trk_n = t_n;
        c_din = (2*W)'(d);
        #1;
        check(hi_term_n == exp_term(model16, up, t_n, top16)[0], "R9 chain flag",
              hi_term_n, exp_term(model16, up, t_n, top16));
        if (!l_n)           model16 = d & top16;
        else if (!p_n && !t_n) model16 = up ? ((model16 + 1) & top16) : ((model16 - 1) & top16);
        @(negedge clk);
        check(int'({hi_cnt, lo_cnt}) == model16, "R9 chain count", {hi_cnt, lo_cnt}, model16);
    endtask

    initial begin
        sync_clear = 1'b1; ld_n = 1'b1; dir_up = 1'b1; en_par_n = 1'b0; en_trk_n = 1'b0;
        din = '0;
        c_clr = 1'b1; c_ld_n = 1'b1; c_up = 1'b1; c_par_n = 1'b0; c_trk_n = 1'b0; c_din = '0;
        repeat (3) @(negedge clk);
        check(count == '0, "R1 reset state", count, 0);
        check({hi_cnt, lo_cnt} == '0, "R1 chain reset", {hi_cnt, lo_cnt}, 0);
        c_clr = 1'b0;

        // R1 overrides load and counting.
        step(0, 0, 1, 0, 0, 8'h5A);
        step(1, 0, 1, 0, 0, 8'h33);
        // R2: load ignores enables and direction.
        step(0, 0, 0, 1, 1, 8'hFE);
        // R5: up to all ones, then wrap.
        step(0, 1, 1, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0);
        // R6: load 1, down through 0 and wrap.
        step(0, 0, 1, 0, 0, 1);
        step(0, 1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0);
        // R7: flag follows direction with no clock (count = all ones now).
        dir_up = 1'b1; en_trk_n = 1'b0; en_par_n = 1'b1; ld_n = 1'b1; #1;
        check(term_n == 1'b0, "R7 dir up at top", term_n, 0);
        dir_up = 1'b0; #1;
        check(term_n == 1'b1, "R7 dir down at top", term_n, 1);
        // R4: trickle high holds and forces flag high.
        step(0, 1, 1, 0, 1, 0);
        // R3 + R8: parallel high holds, flag still active.
        step(0, 1, 1, 1, 0, 0);
        // R8: flag unaffected by a load strobe in the same cycle.
        step(0, 0, 1, 1, 0, 8'h10);

        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            step(r < 2, r >= 2 && r < 10, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0,
                 $urandom_range(0, MAXV));
        end

        // R9 chain: wraps across the stage boundary in both directions.
        @(negedge clk);
        cstep(0, 1, 0, 0, 16'h00FE);
        repeat (4) cstep(1, 1, 0, 0, 0);
        repeat (4) cstep(1, 0, 0, 0, 0);
        cstep(0, 1, 0, 0, 16'hFFFF);
        cstep(1, 1, 0, 0, 0);
        repeat (2) cstep(1, 0, 0, 0, 0);
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            cstep(r >= 3, $urandom_range(0, 9) < 6, $urandom_range(0, 6) == 0,
                  $urandom_range(0, 6) == 0, $urandom_range(0, 65535));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule